// File: doc/BRIEF.md
# Serial Bus Controller Control Register

This block is the host-facing control register of a multi-master serial bus controller. A CPU writes to it over a plain register bus with address, write enable, write data and read data. Its five flags go to the protocol engine: one that switches the unit on, one that asks for bus mastership, one that picks broadcast over individual addressing, and one each to enable slave transmit and slave receive.

The block also keeps host writes from disturbing a transfer that is under way. Once a pending master request has been taken up and the engine reports the master role, host writes are dropped. They stay dropped until the engine reports communication end, frame end or arbitration loss, or until the unit is switched off. Each dropped write produces a one-cycle reject pulse. The master-request flag clears itself while the engine is in the acknowledge slot of the slave address field.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset every control output is low, `wr_rej_o` is low and the register reads 8'h00.
- R2: A read at address 16'hFFB0 returns the flags with unit enable at bit 7, master request at bit 5, broadcast at bit 4, slave transmit at bit 3 and slave receive at bit 2. Bits 6, 1 and 0 always read 0. Any other address reads 8'h00.
- R3: A write to any address other than 16'hFFB0 leaves the register unchanged.
- R4: The lock is set one cycle after a cycle in which unit enable, master request and `role_master_i` are all high. While it is set, a write to the register has no effect, unless a release strobe is present in the same cycle.
- R5: Any of `comm_end_i`, `frame_end_i` or `arb_lost_i` releases the lock. A write in the same cycle as such a strobe is accepted.
- R6: When `role_master_i` is low, writes are accepted even while master request is pending.
- R7: When unit enable is 0, writes are accepted even with master request pending and `role_master_i` high.
- R8: `ack_phase_i` clears master request on the next edge. If a permitted write lands in the same cycle, master request still clears and the other bits take the written values.
- R9: `wr_rej_o` is high for exactly the cycle after each dropped write and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register bus address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| comm_end_i | input | 1 | Engine strobe: communication end |
| frame_end_i | input | 1 | Engine strobe: frame end |
| arb_lost_i | input | 1 | Engine strobe: arbitration lost |
| ack_phase_i | input | 1 | Engine is in the slave address acknowledge slot |
| role_master_i | input | 1 | Engine currently acts as master |
| unit_en_o | output | 1 | Unit enable flag |
| mst_req_o | output | 1 | Master request flag |
| bcast_o | output | 1 | Broadcast select (1) or individual (0) |
| slv_tx_en_o | output | 1 | Slave transmit enable |
| slv_rx_en_o | output | 1 | Slave receive enable |
| wr_rej_o | output | 1 | One-cycle pulse after a dropped write |

## Verification
Writes are driven under each combination that controls the interlock: master role with the lock set, master role with each of the three release strobes on the write cycle, slave role with a request pending, and master role with the unit off. These cases separate a gate that looks at the lock alone from one that also honours role, release and enable. All-ones data and a write to a neighbouring address show the bit mask and the address decode. A write landing on the acknowledge slot shows whether the hardware clear takes priority over the write for the request bit only. A behavioural model is compared against every output on every cycle.

// File: rtl/sbus_ctl_pkg.sv
package sbus_ctl_pkg;
  localparam int BIT_EN  = 7;
  localparam int BIT_MRQ = 5;
  localparam int BIT_BC  = 4;
  localparam int BIT_TX  = 3;
  localparam int BIT_RX  = 2;

  typedef struct packed {
    logic unit_en;
    logic mst_req;
    logic bcast;
    logic slv_tx;
    logic slv_rx;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [7:0] d);
    ctl_t c;
    c.unit_en = d[BIT_EN];
    c.mst_req = d[BIT_MRQ];
    c.bcast   = d[BIT_BC];
    c.slv_tx  = d[BIT_TX];
    c.slv_rx  = d[BIT_RX];
    return c;
  endfunction

  function automatic logic [7:0] ctl_pack(input ctl_t c);
    logic [7:0] d;
    d = '0;
    d[BIT_EN]  = c.unit_en;
    d[BIT_MRQ] = c.mst_req;
    d[BIT_BC]  = c.bcast;
    d[BIT_TX]  = c.slv_tx;
    d[BIT_RX]  = c.slv_rx;
    return d;
  endfunction
endpackage

// File: rtl/sbus_wr_gate.sv
module sbus_wr_gate #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFB0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              unit_en_i,
  input  logic              mst_req_i,
  input  logic              role_master_i,
  input  logic              comm_end_i,
  input  logic              frame_end_i,
  input  logic              arb_lost_i,
  output logic              wr_ok_o,
  output logic              wr_blk_o,
  output logic              lock_o
);
  logic hit, release_ev, lock_q;

  assign hit        = we_i && (addr_i == REG_ADDR);
  assign release_ev = comm_end_i | frame_end_i | arb_lost_i;
  // a release strobe in the write cycle lets the write through
  assign wr_blk_o   = hit && lock_q && unit_en_i && !release_ev;
  assign wr_ok_o    = hit && !wr_blk_o;
  assign lock_o     = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lock_q <= 1'b0;
    else if (!unit_en_i || release_ev)  lock_q <= 1'b0;
    else if (mst_req_i && role_master_i) lock_q <= 1'b1;
  end
endmodule

// File: rtl/sbus_ctl_store.sv
module sbus_ctl_store
  import sbus_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ok_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_phase_i,
  output ctl_t       ctl_o
);
  ctl_t ctl_q;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[6], wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_ok_i)     ctl_q <= ctl_unpack(wdata_i);
      // hardware clear overrides the written request bit
      if (ack_phase_i) ctl_q.mst_req <= 1'b0;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/sbus_rd_mux.sv
module sbus_rd_mux
  import sbus_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFB0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctl_t              ctl_i,
  output logic [7:0]        rdata_o
);
  assign rdata_o = (addr_i == REG_ADDR) ? ctl_pack(ctl_i) : 8'h00;
endmodule

// File: rtl/sbus_ctl_reg.sv
module sbus_ctl_reg
  import sbus_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFB0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              comm_end_i,
  input  logic              frame_end_i,
  input  logic              arb_lost_i,
  input  logic              ack_phase_i,
  input  logic              role_master_i,
  output logic              unit_en_o,
  output logic              mst_req_o,
  output logic              bcast_o,
  output logic              slv_tx_en_o,
  output logic              slv_rx_en_o,
  output logic              wr_rej_o
);
  ctl_t ctl;
  logic wr_ok, wr_blk, lock;
  logic rej_q;

  sbus_wr_gate #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_gate (
    .clk_i, .rst_ni, .addr_i, .we_i,
    .unit_en_i(ctl.unit_en), .mst_req_i(ctl.mst_req),
    .role_master_i, .comm_end_i, .frame_end_i, .arb_lost_i,
    .wr_ok_o(wr_ok), .wr_blk_o(wr_blk), .lock_o(lock)
  );

  sbus_ctl_store u_store (
    .clk_i, .rst_ni, .wr_ok_i(wr_ok), .wdata_i, .ack_phase_i, .ctl_o(ctl)
  );

  sbus_rd_mux #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
    .addr_i, .ctl_i(ctl), .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rej_q <= 1'b0;
    else         rej_q <= wr_blk;
  end

  assign unit_en_o   = ctl.unit_en;
  assign mst_req_o   = ctl.mst_req;
  assign bcast_o     = ctl.bcast;
  assign slv_tx_en_o = ctl.slv_tx;
  assign slv_rx_en_o = ctl.slv_rx;
  assign wr_rej_o    = rej_q;
endmodule

// File: rtl/sbus_ctl_chk.sv
module sbus_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFB0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              comm_end_i,
  input logic              frame_end_i,
  input logic              arb_lost_i,
  input logic              ack_phase_i,
  input logic              unit_en_o,
  input logic              mst_req_o,
  input logic              bcast_o,
  input logic              slv_tx_en_o,
  input logic              slv_rx_en_o,
  input logic              wr_rej_o,
  input logic              lock
);
  logic [4:0] flags;
  logic       rel;
  assign flags = {unit_en_o, mst_req_o, bcast_o, slv_tx_en_o, slv_rx_en_o};
  assign rel   = comm_end_i | frame_end_i | arb_lost_i;

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6] == 1'b0 && rdata_o[1:0] == 2'b00);

  assert_locked_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_ADDR && lock && unit_en_o && !rel && !ack_phase_i)
    |=> $stable(flags) && wr_rej_o);

  assert_release_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_ADDR && rel && !ack_phase_i)
    |=> unit_en_o == $past(wdata_i[7]) && mst_req_o == $past(wdata_i[5]));

  assert_stop_unlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en_o |=> !lock);

  assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_phase_i |=> !mst_req_o);

  assert_rej_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !wr_rej_o);
endmodule

bind sbus_ctl_reg sbus_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
  .comm_end_i, .frame_end_i, .arb_lost_i, .ack_phase_i,
  .unit_en_o, .mst_req_o, .bcast_o, .slv_tx_en_o, .slv_rx_en_o,
  .wr_rej_o, .lock(lock)
);

// File: tb/tb_sbus_ctl_reg.sv
`timescale 1ns/1ps
module tb_sbus_ctl_reg;
  localparam logic [15:0] RA = 16'hFFB0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = RA;
  logic we = 0, ce = 0, fe = 0, al = 0, ack = 0, role = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic en_o, mrq_o, bc_o, tx_o, rx_o, rej_o;

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  logic [7:0] m_reg = 0;
  bit m_lock = 0, m_rej = 0;

  always #2 clk = ~clk;

  sbus_ctl_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .comm_end_i(ce), .frame_end_i(fe), .arb_lost_i(al),
    .ack_phase_i(ack), .role_master_i(role), .unit_en_o(en_o), .mst_req_o(mrq_o),
    .bcast_o(bc_o), .slv_tx_en_o(tx_o), .slv_rx_en_o(rx_o), .wr_rej_o(rej_o)
  );

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic cycle();
    bit hit, rel, blk, was_en, was_mrq;
    @(posedge clk);
    hit = we && addr == RA;
    rel = ce || fe || al;
    was_en = m_reg[7]; was_mrq = m_reg[5];
    blk = hit && m_lock && was_en && !rel;
    if (hit && !blk) m_reg = wdata & 8'hBC;
    if (ack) m_reg[5] = 1'b0;
    if (!was_en || rel) m_lock = 0;
    else if (was_mrq && role) m_lock = 1;
    m_rej = blk;
    @(negedge clk);
    chk({tag, " flags"}, {3'b0, en_o, mrq_o, bc_o, tx_o, rx_o},
        {3'b0, m_reg[7], m_reg[5], m_reg[4], m_reg[3], m_reg[2]});
    chk({tag, " R9 rej"}, {7'b0, rej_o}, {7'b0, m_rej});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    cycle();
    we = 0; ce = 0; fe = 0; al = 0; ack = 0; addr = RA;
  endtask

  task automatic rd(input string t, input logic [15:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(t, rdata, exp);
    addr = RA;
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rd("R1 reset read", RA, 8'h00);
    chk("R1 reset rej", {7'b0, rej_o}, 8'h00);
    rst_n = 1;
    cycle();

    tag = "R2";
    wr(RA, 8'h8C);          rd("R2 readback", RA, 8'h8C);
    wr(RA, 8'hFF);          rd("R2 unused bits zero", RA, 8'hBC);
    rd("R2 other address", 16'hFFB1, 8'h00);

    tag = "R3";
    wr(16'hFFB1, 8'h00);    rd("R3 foreign write ignored", RA, 8'hBC);
    wr(16'h0000, 8'h00);    rd("R3 foreign write ignored 2", RA, 8'hBC);

    tag = "R4";
    role = 1;
    wr(RA, 8'hAC);          // lock sets on this/next edge
    cycle();
    wr(RA, 8'h00);
    chk("R9 reject pulse", {7'b0, rej_o}, 8'h01);
    rd("R4 locked write dropped", RA, 8'hAC);
    cycle();
    chk("R9 reject one cycle", {7'b0, rej_o}, 8'h00);
    wr(RA, 8'h04);          rd("R4 still locked", RA, 8'hAC);

    tag = "R5";
    ce = 1; wr(RA, 8'hA8);  rd("R5 comm_end release", RA, 8'hA8);
    cycle(); cycle();
    fe = 1; wr(RA, 8'hB0);  rd("R5 frame_end release", RA, 8'hB0);
    cycle(); cycle();
    al = 1; wr(RA, 8'hA4);  rd("R5 arb_lost release", RA, 8'hA4);
    cycle();

    tag = "R6";
    role = 0; ce = 1; cycle(); ce = 0;
    wr(RA, 8'hA0); cycle();
    wr(RA, 8'h88);          rd("R6 slave write accepted", RA, 8'h88);

    tag = "R7";
    role = 1;
    wr(RA, 8'h20); cycle(); cycle();
    wr(RA, 8'h0C);          rd("R7 stopped unit write accepted", RA, 8'h0C);

    tag = "R8";
    role = 0;
    wr(RA, 8'hB0);
    ack = 1; cycle(); ack = 0;
    rd("R8 hw clear", RA, 8'h90);
    ack = 1; wr(RA, 8'hBC);  rd("R8 clear beats write", RA, 8'h9C);

    repeat (4) cycle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule